// File: doc/BRIEF.md
# Handshake-Gating Stream Controller

This block sits on a valid/ready sample stream between a producing FIFO and a consuming FIFO, one sample per clock. It cannot stall either side. It lets a transfer happen by passing the two handshake wires through, and it stops transfers by forcing both wires low. A run is started by a command and then by a trigger pulse. It then continues until a stop command (continuous mode), or it ends by itself after a programmed number of transfers (finite burst mode).

Flow control is left to the system designer, so the controller watches for samples that are lost and for output slots that go unfilled. Overflow is raised when the source offers a sample that the destination cannot take. Underflow is raised when the destination is ready but the source has nothing. Both flags are sticky. The control side uses pulse commands, a mode bit, a length word and a write-one-to-clear flag strobe.

Top module: `stream_gate`

## Requirements
- R1: Once reset has been released, the state is IDLE (code 0), both flags read 0, and the forwarded valid and forwarded ready are both low.
- R2: In every state other than RUNNING (code 2), `dst_valid_o` and `src_ready_o` are held low whatever the stream inputs do, and neither flag is set.
- R3: A start pulse in IDLE moves the state to ARMED (code 1) one cycle later. In any other state a start pulse is ignored.
- R4: A trigger pulse in ARMED starts the run one cycle later. In IDLE a trigger pulse is ignored.
- R5: A stop pulse returns the state to IDLE (code 0) one cycle later from any state, and it takes priority over a start or trigger pulse in the same cycle.
- R6: In RUNNING, `dst_valid_o` follows `src_valid_i`, `src_ready_o` follows `dst_ready_i`, and `dst_data_o` equals `src_data_i`, all combinationally in the same cycle.
- R7: In burst mode (`cont_mode_i`=0), the run passes exactly N transfers, where N is `burst_len_i` captured in the trigger cycle. The state then becomes DONE (code 3) on the edge that completes the Nth transfer. Later changes to `burst_len_i` have no effect on the run in progress.
- R8: In burst mode with N=0, a trigger moves ARMED straight to DONE and no transfer takes place.
- R9: In continuous mode (`cont_mode_i`=1), RUNNING is held until a stop pulse, however many transfers happen.
- R10: In RUNNING, a cycle with `src_valid_i`=1 and `dst_ready_i`=0 sets `ovf_o` from the next cycle on, and the flag stays set.
- R11: In RUNNING, a cycle with `dst_ready_i`=1 and `src_valid_i`=0 sets `unf_o` from the next cycle on, and the flag stays set.
- R12: Writing a 1 to bit 0 of `flag_clr_i` clears `ovf_o`, and writing a 1 to bit 1 clears `unf_o`, both one cycle later. If a new event and a clear happen in the same cycle, the event wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| src_valid_i | input | 1 | Valid from the producing FIFO |
| src_ready_o | output | 1 | Gated ready returned to the producing FIFO |
| src_data_i | input | DATA_W | Sample from the producing FIFO |
| dst_valid_o | output | 1 | Gated valid to the consuming FIFO |
| dst_ready_i | input | 1 | Ready from the consuming FIFO |
| dst_data_o | output | DATA_W | Sample to the consuming FIFO |
| cmd_start_i | input | 1 | Start pulse (arm) |
| cmd_stop_i | input | 1 | Stop pulse (abort to IDLE) |
| trig_i | input | 1 | Trigger pulse |
| cont_mode_i | input | 1 | 1 = continuous, 0 = finite burst |
| burst_len_i | input | LEN_W | Burst length N, captured at trigger |
| flag_clr_i | input | 2 | Write-one-to-clear: bit 0 overflow, bit 1 underflow |
| state_o | output | 2 | 0 IDLE, 1 ARMED, 2 RUNNING, 3 DONE |
| ovf_o | output | 1 | Sticky overflow flag |
| unf_o | output | 1 | Sticky underflow flag |

## Verification
The gated handshake and the data are combinational, so the bench checks them in the same cycle the stimulus is applied, shortly after the falling edge on which it was driven. State changes and flag changes pass through exactly one register. They are therefore sampled at the next falling edge, one full cycle after the command, trigger or stream event that causes them. In the burst sweep, transfers are counted from the port handshake in each cycle. The total is compared with N after the run, under both a steady-ready and an alternating-ready pattern, with the length input corrupted after the trigger.

// File: rtl/stream_gate_pkg.sv
package stream_gate_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_RUN   = 2'd2,
    ST_DONE  = 2'd3
  } gate_state_t;

  localparam int unsigned NUM_FLAGS = 2;
  localparam int unsigned FLAG_OVF  = 0;
  localparam int unsigned FLAG_UNF  = 1;
endpackage

// File: rtl/gate_fsm.sv
module gate_fsm
  import stream_gate_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_i,
  input  logic        stop_i,
  input  logic        trig_i,
  input  logic        cont_i,
  input  logic        len_zero_i,
  input  logic        last_xfer_i,
  output gate_state_t state_o,
  output logic        load_o
);
  gate_state_t state_q, state_d;

  // Trigger accepted in ARMED (a stop in the same cycle wins)
  assign load_o = (state_q == ST_ARMED) && trig_i && !stop_i;

  always_comb begin
    state_d = state_q;
    if (stop_i) begin
      state_d = ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE:  if (start_i) state_d = ST_ARMED;
        ST_ARMED: if (trig_i)  state_d = (!cont_i && len_zero_i) ? ST_DONE : ST_RUN;
        ST_RUN:   if (!cont_i && last_xfer_i) state_d = ST_DONE;
        ST_DONE:  state_d = ST_DONE;
        default:  state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign state_o = state_q;
endmodule

// File: rtl/burst_counter.sv
module burst_counter #(
  parameter int unsigned LEN_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             xfer_i,
  output logic             last_o
);
  logic [LEN_W-1:0] len_q, cnt_q, cnt_d;
  logic             cnt_en;

  assign cnt_en = load_i | xfer_i;
  assign cnt_d  = load_i ? '0 : cnt_q + 1'b1;
  assign last_o = xfer_i && (cnt_q == len_q - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q <= '0;
    end else if (load_i) begin
      len_q <= len_i;
    end
  end
endmodule

// File: rtl/sticky_flags.sv
module sticky_flags #(
  parameter int unsigned N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flag_o
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    logic q, d, en;
    assign en = set_i[i] | clr_i[i];
    assign d  = set_i[i];           // event wins over a clear
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= 1'b0;
      else if (en) q <= d;
    end
    assign flag_o[i] = q;
  end
endmodule

// File: rtl/stream_gate.sv
module stream_gate
  import stream_gate_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned LEN_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              src_valid_i,
  output logic              src_ready_o,
  input  logic [DATA_W-1:0] src_data_i,
  output logic              dst_valid_o,
  input  logic              dst_ready_i,
  output logic [DATA_W-1:0] dst_data_o,
  input  logic              cmd_start_i,
  input  logic              cmd_stop_i,
  input  logic              trig_i,
  input  logic              cont_mode_i,
  input  logic [LEN_W-1:0]  burst_len_i,
  input  logic [1:0]        flag_clr_i,
  output logic [1:0]        state_o,
  output logic              ovf_o,
  output logic              unf_o
);
  localparam int unsigned SYNC_STAGES = 2;

  // Reset: asserted asynchronously, released on the clock
  logic [SYNC_STAGES-1:0] rst_sync_q;
  logic                   rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[SYNC_STAGES-1];

  gate_state_t          state;
  logic                 load, last_xfer, running, xfer;
  logic [NUM_FLAGS-1:0] flag_set, flags;

  assign running     = (state == ST_RUN);
  assign dst_valid_o = running & src_valid_i;
  assign src_ready_o = running & dst_ready_i;
  assign dst_data_o  = src_data_i;
  assign xfer        = running & src_valid_i & dst_ready_i;

  gate_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .start_i    (cmd_start_i),
    .stop_i     (cmd_stop_i),
    .trig_i     (trig_i),
    .cont_i     (cont_mode_i),
    .len_zero_i (burst_len_i == '0),
    .last_xfer_i(last_xfer),
    .state_o    (state),
    .load_o     (load)
  );

  burst_counter #(.LEN_W(LEN_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_int_n),
    .load_i(load),
    .len_i (burst_len_i),
    .xfer_i(xfer),
    .last_o(last_xfer)
  );

  assign flag_set[FLAG_OVF] = running &  src_valid_i & ~dst_ready_i;
  assign flag_set[FLAG_UNF] = running & ~src_valid_i &  dst_ready_i;

  sticky_flags #(.N(NUM_FLAGS)) u_flags (
    .clk   (clk),
    .rst_n (rst_int_n),
    .set_i (flag_set),
    .clr_i (flag_clr_i),
    .flag_o(flags)
  );

  assign state_o = state;
  assign ovf_o   = flags[FLAG_OVF];
  assign unf_o   = flags[FLAG_UNF];
endmodule

// File: rtl/stream_gate_checker.sv
module stream_gate_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       src_valid_i,
  input logic       src_ready_o,
  input logic       dst_valid_o,
  input logic       dst_ready_i,
  input logic       cmd_start_i,
  input logic       cmd_stop_i,
  input logic [1:0] flag_clr_i,
  input logic [1:0] state_o,
  input logic       ovf_o,
  input logic       unf_o
);
  p_gate_closed_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o != 2'd2) |-> (!dst_valid_o && !src_ready_o));

  p_arm_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 2'd0 && cmd_start_i && !cmd_stop_i) |=> (state_o == 2'd1));

  p_stop_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_stop_i |=> (state_o == 2'd0));

  p_pass_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 2'd2) |-> (dst_valid_o == src_valid_i && src_ready_o == dst_ready_i));

  p_overflow_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 2'd2 && src_valid_i && !dst_ready_i) |=> ovf_o);

  p_underflow_set_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 2'd2 && !src_valid_i && dst_ready_i) |=> unf_o);

  p_overflow_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_o && !flag_clr_i[0]) |=> ovf_o);

  p_underflow_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (unf_o && !flag_clr_i[1]) |=> unf_o);
endmodule

bind stream_gate stream_gate_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_int_n),
  .src_valid_i(src_valid_i),
  .src_ready_o(src_ready_o),
  .dst_valid_o(dst_valid_o),
  .dst_ready_i(dst_ready_i),
  .cmd_start_i(cmd_start_i),
  .cmd_stop_i (cmd_stop_i),
  .flag_clr_i (flag_clr_i),
  .state_o    (state_o),
  .ovf_o      (ovf_o),
  .unf_o      (unf_o)
);

// File: tb/stream_gate_test.sv
`timescale 1ns/1ps
module stream_gate_test;
  localparam int DATA_W = 16;
  localparam int LEN_W  = 32;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              src_valid_i, dst_ready_i;
  logic              src_ready_o, dst_valid_o;
  logic [DATA_W-1:0] src_data_i, dst_data_o;
  logic              cmd_start_i, cmd_stop_i, trig_i, cont_mode_i;
  logic [LEN_W-1:0]  burst_len_i;
  logic [1:0]        flag_clr_i;
  logic [1:0]        state_o;
  logic              ovf_o, unf_o;

  int n_cmp = 0;
  int n_bad = 0;

  always #4 clk = ~clk;   // 125 MHz

  stream_gate #(.DATA_W(DATA_W), .LEN_W(LEN_W)) uut (
    .clk(clk), .rst_n(rst_n),
    .src_valid_i(src_valid_i), .src_ready_o(src_ready_o), .src_data_i(src_data_i),
    .dst_valid_o(dst_valid_o), .dst_ready_i(dst_ready_i), .dst_data_o(dst_data_o),
    .cmd_start_i(cmd_start_i), .cmd_stop_i(cmd_stop_i), .trig_i(trig_i),
    .cont_mode_i(cont_mode_i), .burst_len_i(burst_len_i), .flag_clr_i(flag_clr_i),
    .state_o(state_o), .ovf_o(ovf_o), .unf_o(unf_o)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // advance to the next falling edge and settle
  task automatic nxt();
    @(negedge clk);
    #1;
  endtask

  task automatic idle_inputs();
    src_valid_i = 0; dst_ready_i = 0; cmd_start_i = 0; cmd_stop_i = 0;
    trig_i = 0; flag_clr_i = 2'b00;
  endtask

  task automatic clear_flags();
    idle_inputs();
    flag_clr_i = 2'b11;
    nxt();
    flag_clr_i = 2'b00;
  endtask

  task automatic pulse_start();
    idle_inputs(); cmd_start_i = 1; nxt(); cmd_start_i = 0;
  endtask

  task automatic pulse_stop();
    idle_inputs(); cmd_stop_i = 1; nxt(); cmd_stop_i = 0;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : main
    rst_n = 0; src_data_i = '0; cont_mode_i = 0; burst_len_i = '0;
    idle_inputs();
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) nxt();

    // R1 reset state
    chk("R1 state", state_o, 0);
    chk("R1 ovf", ovf_o, 0);
    chk("R1 unf", unf_o, 0);
    chk("R1 dst_valid", dst_valid_o, 0);
    chk("R1 src_ready", src_ready_o, 0);

    // R2/R4: IDLE keeps the gate closed; trigger ignored
    src_valid_i = 1; dst_ready_i = 1; trig_i = 1;
    #1;
    chk("R2 idle dst_valid", dst_valid_o, 0);
    chk("R2 idle src_ready", src_ready_o, 0);
    nxt();
    chk("R4 trig ignored in idle", state_o, 0);
    trig_i = 0; dst_ready_i = 0;
    nxt();
    chk("R2 no ovf outside run", ovf_o, 0);
    src_valid_i = 0; dst_ready_i = 1;
    nxt();
    chk("R2 no unf outside run", unf_o, 0);

    // R5: stop wins over start
    idle_inputs(); cmd_start_i = 1; cmd_stop_i = 1;
    nxt();
    chk("R5 stop beats start", state_o, 0);

    // R3: arm, repeat start ignored, gate closed in ARMED
    pulse_start();
    chk("R3 armed", state_o, 1);
    src_valid_i = 1; dst_ready_i = 1; cmd_start_i = 1;
    #1;
    chk("R2 armed dst_valid", dst_valid_o, 0);
    chk("R2 armed src_ready", src_ready_o, 0);
    nxt();
    chk("R3 start ignored in armed", state_o, 1);

    // R4/R9: continuous run
    idle_inputs(); cont_mode_i = 1; trig_i = 1;
    nxt();
    chk("R4 running", state_o, 2);
    trig_i = 0;
    for (int c = 0; c < 4; c++) begin
      logic v, r;
      clear_flags();
      v = c[0]; r = c[1];
      src_valid_i = v; dst_ready_i = r; src_data_i = DATA_W'(16'h1111 * (c + 3));
      #1;
      chk("R6 valid follows", dst_valid_o, v);
      chk("R6 ready follows", src_ready_o, r);
      chk("R6 data", dst_data_o, DATA_W'(16'h1111 * (c + 3)));
      nxt();
      chk("R10 overflow", ovf_o, (v && !r) ? 1 : 0);
      chk("R11 underflow", unf_o, (!v && r) ? 1 : 0);
      src_valid_i = 1; dst_ready_i = 1;
      nxt();
      chk("R10 ovf sticky", ovf_o, (v && !r) ? 1 : 0);
      chk("R11 unf sticky", unf_o, (!v && r) ? 1 : 0);
    end
    // R12 selective clear and event-wins
    idle_inputs(); src_valid_i = 1; dst_ready_i = 0; nxt();
    src_valid_i = 0; dst_ready_i = 1; nxt();
    idle_inputs(); src_valid_i = 1; dst_ready_i = 1; flag_clr_i = 2'b01; nxt();
    chk("R12 ovf cleared", ovf_o, 0);
    chk("R12 unf kept", unf_o, 1);
    flag_clr_i = 2'b10; nxt();
    chk("R12 unf cleared", unf_o, 0);
    src_valid_i = 1; dst_ready_i = 0; flag_clr_i = 2'b01; nxt();
    chk("R12 event beats clear", ovf_o, 1);
    clear_flags();
    src_valid_i = 1; dst_ready_i = 1;
    repeat (20) nxt();
    chk("R9 continuous holds", state_o, 2);
    pulse_stop();
    chk("R5 stop from run", state_o, 0);

    // R7/R8 burst sweep
    cont_mode_i = 0;
    for (int n = 0; n <= 5; n++) begin
      for (int pat = 0; pat < 2; pat++) begin
        int cnt;
        clear_flags();
        pulse_start();
        burst_len_i = LEN_W'(n); trig_i = 1;
        nxt();
        trig_i = 0; burst_len_i = 32'd99;
        if (n == 0) begin
          chk("R8 zero length done", state_o, 3);
        end else begin
          chk("R4 burst running", state_o, 2);
        end
        cnt = 0;
        for (int c = 0; c < 3 * n + 6; c++) begin
          src_valid_i = 1;
          dst_ready_i = (pat == 1) ? c[0] : 1'b1;
          #1;
          if (dst_valid_o && dst_ready_i) cnt++;
          nxt();
        end
        chk($sformatf("R7 transfers n=%0d pat=%0d", n, pat), cnt, n);
        chk("R7 done", state_o, 3);
        src_valid_i = 1; dst_ready_i = 1;
        #1;
        chk("R2 done gate closed", dst_valid_o | src_ready_o, 0);
        pulse_stop();
        chk("R5 stop from done", state_o, 0);
      end
    end

    // R5 stop from ARMED
    pulse_start();
    pulse_stop();
    chk("R5 stop from armed", state_o, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule